// File: doc/BRIEF.md
# Prefix-Compare Search Issue Controller

This block sits in front of a two-stage search array, where each stored word is split into a short leading segment and a long trailing segment. It takes a stream of search keys over a valid/ready handshake and decides, for each key, how soon it may be sent to the array. The decision rests on the key's leading `PFX_W` bits, called the prefix. A key whose prefix differs from those of the most recently accepted keys still in flight can only match a different set of entries. Such a key is sent back-to-back, in fast mode. A key whose prefix equals one of theirs would reuse the same entries. It is held at the input until the array reports that the earlier search has finished, and it then goes out in slow mode.

Each accepted key is given a free tag and is loaded into two separate search-line registers, one for the prefix and one for the remainder. These registers are offered to the array under a second valid/ready handshake, together with the tag and a mode flag. The array later returns one completion pulse carrying that tag, which frees the tag. The number of outstanding tags is capped by `SLOTS`. Two counters record how many keys were accepted in each mode.

Top module: `sic_issue_ctrl`

## Requirements
- R1: After reset, `iss_valid` is 0, both mode counters are 0, and `in_ready` is 1.
- R2: In the cycle after a key is accepted (`in_valid && in_ready` at an edge), `iss_valid` is 1. `iss_pfx` then equals key bits [KEY_W-1 : KEY_W-PFX_W] and `iss_rem` equals the remaining low bits.
- R3: `in_ready` is 1 whenever the issue register is empty or being taken, fewer than `SLOTS` keys are outstanding, and no prefix conflict exists. A key accepted without having been blocked by a conflict is issued with `iss_slow` = 0.
- R4: A prefix conflict exists when the presented key's prefix equals the prefix of one of the `HIST` most recently accepted keys that is still outstanding. While the conflict lasts, `in_ready` is 0. A key that was presented while a conflict blocked it is issued with `iss_slow` = 1 once the blocking completion has arrived.
- R5: While `iss_valid` is 1 and `iss_ready` is 0, `iss_pfx`, `iss_rem`, `iss_tag` and `iss_slow` keep their values and `in_ready` is 0.
- R6: A key is outstanding from the edge at which it is accepted until the edge at which its completion is sampled. While `SLOTS` keys are outstanding, `in_ready` is 0 regardless of the prefix.
- R7: The tag of each newly issued key is below `SLOTS` and differs from the tag of every key outstanding before its acceptance.
- R8: A completion whose tag is not outstanding changes nothing: readiness and tag use continue as if the pulse had not occurred.
- R9: `fast_cnt` and `slow_cnt` count accepted keys by their `iss_slow` value, one per accepted key.
- R10: An outstanding key with the same prefix does not block a new key once `HIST` newer keys have been accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Search key offered |
| in_ready | output | 1 | Key accepted at this edge if valid |
| in_key | input | KEY_W | Search key, prefix in the top bits |
| iss_valid | output | 1 | Search-line registers hold a key for the array |
| iss_ready | input | 1 | Array takes the offered key |
| iss_pfx | output | PFX_W | Prefix search-line register |
| iss_rem | output | KEY_W-PFX_W | Remainder search-line register |
| iss_tag | output | TAG_W | Tag of the offered key |
| iss_slow | output | 1 | 1 = slow-mode issue, 0 = fast-mode issue |
| cmp_valid | input | 1 | Completion pulse from the array |
| cmp_tag | input | TAG_W | Tag of the completed search |
| fast_cnt | output | CNT_W | Keys accepted in fast mode |
| slow_cnt | output | CNT_W | Keys accepted in slow mode |

## Verification
The assertions check, on every cycle, that the offered key holds under back-pressure, and that a detected conflict or a full tag pool keeps `in_ready` low. They also check that a fresh tag is occupied after acceptance, that a stray completion leaves the occupancy unchanged, and that the counters advance by one per acceptance. Only the bench scenarios can show which keys must wait. They do this by comparing `in_ready` on every cycle against an independent model of the outstanding prefixes and the acceptance history. The same model confirms that each issued key carries the right split, tag and mode, and that older same-prefix keys outside the history window do not block.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } issue_mode_e;

  function automatic int unsigned pop32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += {31'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/sic_slot_table.sv
module sic_slot_table #(
  parameter int SLOTS = 4,
  parameter int PFX_W = 4,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [PFX_W-1:0]       alloc_pfx,
  input  logic                   cmp_valid,
  input  logic [TAG_W-1:0]       cmp_tag,
  output logic [SLOTS-1:0]       busy_vec,
  output logic [SLOTS*PFX_W-1:0] slot_pfx,
  output logic [TAG_W-1:0]       free_tag
);
  function automatic logic [TAG_W-1:0] lowest_free(input logic [SLOTS-1:0] b);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (!b[i]) t = TAG_W'(i);
    return t;
  endfunction

  assign free_tag = lowest_free(busy_vec);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic take_here, done_here;
    assign take_here = alloc_en && (free_tag == TAG_W'(i));
    assign done_here = cmp_valid && (cmp_tag == TAG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_vec[i] <= 1'b0;
      end else if (take_here) begin
        busy_vec[i] <= 1'b1;
      end else if (done_here) begin
        busy_vec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_pfx[i*PFX_W +: PFX_W] <= '0;
      end else if (take_here) begin
        slot_pfx[i*PFX_W +: PFX_W] <= alloc_pfx;
      end
    end
  end
endmodule

// File: rtl/sic_prefix_hist.sv
module sic_prefix_hist #(
  parameter int HIST  = 1,
  parameter int SLOTS = 4,
  parameter int PFX_W = 4,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [TAG_W-1:0]       push_tag,
  input  logic [SLOTS-1:0]       busy_vec,
  input  logic [SLOTS*PFX_W-1:0] slot_pfx,
  input  logic [PFX_W-1:0]       probe_pfx,
  output logic                   conflict
);
  logic [TAG_W-1:0] hist_tag [HIST];
  logic [HIST-1:0]  hist_v;
  logic [HIST-1:0]  hit;

  function automatic logic [PFX_W-1:0] pfx_at(input logic [SLOTS*PFX_W-1:0] all,
                                               input logic [TAG_W-1:0] t);
    logic [PFX_W-1:0] p;
    p = '0;
    for (int i = 0; i < SLOTS; i++) if (t == TAG_W'(i)) p = all[i*PFX_W +: PFX_W];
    return p;
  endfunction

  function automatic logic busy_at(input logic [SLOTS-1:0] b, input logic [TAG_W-1:0] t);
    logic r;
    r = 1'b0;
    for (int i = 0; i < SLOTS; i++) if (t == TAG_W'(i)) r = b[i];
    return r;
  endfunction

  for (genvar h = 0; h < HIST; h++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_tag[h] <= '0;
        hist_v[h]   <= 1'b0;
      end else if (push) begin
        if (h == 0) begin
          hist_tag[h] <= push_tag;
          hist_v[h]   <= 1'b1;
        end else begin
          hist_tag[h] <= hist_tag[h-1];
          hist_v[h]   <= hist_v[h-1];
        end
      end
    end

    assign hit[h] = hist_v[h] && busy_at(busy_vec, hist_tag[h]) &&
                    (pfx_at(slot_pfx, hist_tag[h]) == probe_pfx);
  end

  assign conflict = |hit;
endmodule

// File: rtl/sic_issue_stage.sv
module sic_issue_stage #(
  parameter int PFX_W = 4,
  parameter int REM_W = 12,
  parameter int TAG_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PFX_W-1:0]    ld_pfx,
  input  logic [REM_W-1:0]    ld_rem,
  input  logic [TAG_W-1:0]    ld_tag,
  input  sic_pkg::issue_mode_e ld_mode,
  input  logic                take,
  output logic                iss_valid,
  output logic [PFX_W-1:0]    iss_pfx,
  output logic [REM_W-1:0]    iss_rem,
  output logic [TAG_W-1:0]    iss_tag,
  output logic                iss_slow
);
  always_ff @(posedge clk) begin
    if (!rst_n) iss_valid <= 1'b0;
    else if (load) iss_valid <= 1'b1;
    else if (take) iss_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_pfx <= '0;
      iss_tag <= '0;
      iss_slow <= 1'b0;
    end else if (load) begin
      iss_pfx <= ld_pfx;
      iss_tag <= ld_tag;
      iss_slow <= (ld_mode == sic_pkg::MODE_SLOW);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) iss_rem <= '0;
    else if (load) iss_rem <= ld_rem;
  end
endmodule

// File: rtl/sic_issue_ctrl.sv
module sic_issue_ctrl #(
  parameter int KEY_W = 16,
  parameter int PFX_W = 4,
  parameter int HIST  = 1,
  parameter int SLOTS = 4,
  parameter int CNT_W = 16,
  localparam int REM_W = KEY_W - PFX_W,
  localparam int TAG_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [PFX_W-1:0] iss_pfx,
  output logic [REM_W-1:0] iss_rem,
  output logic [TAG_W-1:0] iss_tag,
  output logic             iss_slow,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic [CNT_W-1:0] fast_cnt,
  output logic [CNT_W-1:0] slow_cnt
);
  import sic_pkg::*;

  function automatic logic [PFX_W-1:0] key_prefix(input logic [KEY_W-1:0] k);
    return k[KEY_W-1 -: PFX_W];
  endfunction

  function automatic logic [REM_W-1:0] key_rest(input logic [KEY_W-1:0] k);
    return k[REM_W-1:0];
  endfunction

  logic [SLOTS-1:0]       busy_vec;
  logic [SLOTS*PFX_W-1:0] slot_pfx;
  logic [TAG_W-1:0]       free_tag;
  logic [TAG_W:0]         busy_cnt;
  logic                   full, conflict, can_load, accept, slow_seen;
  issue_mode_e            acc_mode;

  assign busy_cnt = (TAG_W + 1)'(pop32(32'(busy_vec)));
  assign full     = (busy_cnt == (TAG_W + 1)'(SLOTS));
  assign can_load = !iss_valid || iss_ready;
  assign in_ready = can_load && !full && !conflict;
  assign accept   = in_valid && in_ready;
  assign acc_mode = slow_seen ? MODE_SLOW : MODE_FAST;

  always_ff @(posedge clk) begin
    if (!rst_n) slow_seen <= 1'b0;
    else if (accept || !in_valid) slow_seen <= 1'b0;
    else if (conflict) slow_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_cnt <= '0;
      slow_cnt <= '0;
    end else if (accept) begin
      if (acc_mode == MODE_SLOW) slow_cnt <= slow_cnt + 1'b1;
      else fast_cnt <= fast_cnt + 1'b1;
    end
  end

  sic_slot_table #(.SLOTS(SLOTS), .PFX_W(PFX_W), .TAG_W(TAG_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept), .alloc_pfx(key_prefix(in_key)),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .busy_vec(busy_vec), .slot_pfx(slot_pfx), .free_tag(free_tag)
  );

  sic_prefix_hist #(.HIST(HIST), .SLOTS(SLOTS), .PFX_W(PFX_W), .TAG_W(TAG_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_tag(free_tag),
    .busy_vec(busy_vec), .slot_pfx(slot_pfx),
    .probe_pfx(key_prefix(in_key)), .conflict(conflict)
  );

  sic_issue_stage #(.PFX_W(PFX_W), .REM_W(REM_W), .TAG_W(TAG_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .ld_pfx(key_prefix(in_key)), .ld_rem(key_rest(in_key)),
    .ld_tag(free_tag), .ld_mode(acc_mode), .take(iss_ready),
    .iss_valid(iss_valid), .iss_pfx(iss_pfx), .iss_rem(iss_rem),
    .iss_tag(iss_tag), .iss_slow(iss_slow)
  );
endmodule

// File: rtl/sic_issue_checker.sv
module sic_issue_checker #(
  parameter int PFX_W = 4,
  parameter int REM_W = 12,
  parameter int SLOTS = 4,
  parameter int TAG_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             accept,
  input logic             conflict,
  input logic             full,
  input logic [SLOTS-1:0] busy_vec,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [PFX_W-1:0] iss_pfx,
  input logic [REM_W-1:0] iss_rem,
  input logic [TAG_W-1:0] iss_tag,
  input logic             iss_slow,
  input logic             cmp_valid,
  input logic [TAG_W-1:0] cmp_tag,
  input logic [CNT_W-1:0] fast_cnt,
  input logic [CNT_W-1:0] slow_cnt
);
  logic cmp_stray;
  assign cmp_stray = cmp_valid && ((32'(cmp_tag) >= SLOTS) || !busy_vec[cmp_tag]);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_pfx) && $stable(iss_rem) &&
    $stable(iss_tag) && $stable(iss_slow)); // R5
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |-> !in_ready); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready); // R6
  AST_CONFLICT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !in_ready); // R4
  AST_TAG_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> iss_valid && busy_vec[iss_tag]); // R7
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_stray && !accept |=> busy_vec == $past(busy_vec)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (fast_cnt + slow_cnt) == ($past(fast_cnt + slow_cnt) + 1'b1)); // R9
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(fast_cnt) && $stable(slow_cnt)); // R9
endmodule

bind sic_issue_ctrl sic_issue_checker #(
  .PFX_W(PFX_W), .REM_W(REM_W), .SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .accept(accept),
  .conflict(conflict), .full(full), .busy_vec(busy_vec),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pfx(iss_pfx),
  .iss_rem(iss_rem), .iss_tag(iss_tag), .iss_slow(iss_slow),
  .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
  .fast_cnt(fast_cnt), .slow_cnt(slow_cnt)
);

// File: tb/sic_issue_ctrl_test.sv
module sic_issue_ctrl_test;
  localparam int KEY_W = 16, PFX_W = 4, HIST = 1, SLOTS = 4, CNT_W = 16;
  localparam int REM_W = KEY_W - PFX_W;
  localparam int TAG_W = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, iss_valid, iss_ready = 0, iss_slow, cmp_valid = 0;
  logic [KEY_W-1:0] in_key = '0;
  logic [PFX_W-1:0] iss_pfx;
  logic [REM_W-1:0] iss_rem;
  logic [TAG_W-1:0] iss_tag, cmp_tag = '0;
  logic [CNT_W-1:0] fast_cnt, slow_cnt;

  always #2 clk = ~clk;

  sic_issue_ctrl #(.KEY_W(KEY_W), .PFX_W(PFX_W), .HIST(HIST), .SLOTS(SLOTS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pfx(iss_pfx), .iss_rem(iss_rem),
    .iss_tag(iss_tag), .iss_slow(iss_slow), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .fast_cnt(fast_cnt), .slow_cnt(slow_cnt));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // independent model
  bit               m_busy [SLOTS];
  bit               m_hand [SLOTS];
  logic [PFX_W-1:0] m_pfx  [SLOTS];
  int               m_hist [HIST];
  int               m_nfast = 0, m_nslow = 0;
  bit               m_waited = 0, exp_iss_v = 0;
  bit               pend_acc = 0, pend_slow = 0;
  logic [KEY_W-1:0] pend_key;
  bit               busy_snap [SLOTS];
  bit               hold_chk = 0, holding = 0;
  logic [KEY_W+TAG_W:0] held;
  int cov_slow = 0, cov_full = 0, cov_old = 0, cov_stray = 0;

  function automatic int n_busy();
    int n = 0;
    for (int i = 0; i < SLOTS; i++) n += m_busy[i];
    return n;
  endfunction

  function automatic bit m_conflict(input logic [PFX_W-1:0] p);
    bit c = 0;
    for (int h = 0; h < HIST; h++)
      if (m_hist[h] >= 0 && m_busy[m_hist[h]] && m_pfx[m_hist[h]] == p) c = 1;
    return c;
  endfunction

  function automatic bit m_older_same(input logic [PFX_W-1:0] p);
    bit c = 0;
    for (int i = 0; i < SLOTS; i++) if (m_busy[i] && m_pfx[i] == p) c = 1;
    return c;
  endfunction

  task automatic run_phase(input int cycles, input int p_valid, input int p_ready,
                           input int p_cmp, input int pfx_span);
    for (int c = 0; c < cycles; c++) begin
      bit acc, exp_rdy, cf;
      logic [PFX_W-1:0] kp;
      @(negedge clk);
      // (a) registered outputs after the last edge
      chk(iss_valid == exp_iss_v, "R2 iss_valid", iss_valid, exp_iss_v);
      if (pend_acc) begin
        chk(iss_pfx == pend_key[KEY_W-1 -: PFX_W], "R2 prefix", iss_pfx, pend_key[KEY_W-1 -: PFX_W]);
        chk(iss_rem == pend_key[REM_W-1:0], "R2 remainder", iss_rem, pend_key[REM_W-1:0]);
        chk(iss_slow == pend_slow, pend_slow ? "R4 slow mode" : "R3 fast mode", iss_slow, pend_slow);
        chk(32'(iss_tag) < SLOTS && !busy_snap[iss_tag], "R7 fresh tag", iss_tag, -1);
        m_busy[iss_tag] = 1; m_hand[iss_tag] = 0;
        m_pfx[iss_tag] = pend_key[KEY_W-1 -: PFX_W];
        for (int h = HIST - 1; h > 0; h--) m_hist[h] = m_hist[h-1];
        m_hist[0] = int'(iss_tag);
        if (pend_slow) m_nslow++; else m_nfast++;
        pend_acc = 0;
      end
      if (hold_chk)
        chk({iss_slow, iss_tag, iss_pfx, iss_rem} == held, "R5 hold", {iss_slow, iss_tag, iss_pfx, iss_rem}, held);
      chk(fast_cnt == CNT_W'(m_nfast), "R9 fast count", fast_cnt, m_nfast);
      chk(slow_cnt == CNT_W'(m_nslow), "R9 slow count", slow_cnt, m_nslow);
      // (b) new stimulus
      if (!holding) begin
        in_valid = (($urandom % 100) < p_valid);
        in_key = {PFX_W'($urandom % pfx_span), REM_W'($urandom)};
      end
      iss_ready = (($urandom % 100) < p_ready);
      cmp_valid = 0;
      if (($urandom % 100) < p_cmp) begin
        int t = $urandom % SLOTS;
        if (m_busy[t] && m_hand[t]) begin cmp_valid = 1; cmp_tag = TAG_W'(t); end
        else if (!m_busy[t]) begin cmp_valid = 1; cmp_tag = TAG_W'(t); cov_stray++; end
      end
      #1;
      // (c) readiness against the model
      kp = in_key[KEY_W-1 -: PFX_W];
      cf = m_conflict(kp);
      exp_rdy = (!exp_iss_v || iss_ready) && n_busy() < SLOTS && !cf;
      if (n_busy() == SLOTS) chk(in_ready == exp_rdy, "R6 cap", in_ready, exp_rdy);
      else if (cf) chk(in_ready == exp_rdy, "R4 conflict", in_ready, exp_rdy);
      else if (exp_iss_v && !iss_ready) chk(in_ready == exp_rdy, "R5 back-pressure", in_ready, exp_rdy);
      else chk(in_ready == exp_rdy, "R3 ready", in_ready, exp_rdy);
      if (in_valid && n_busy() == SLOTS) cov_full++;
      // (d) model update for the coming edge
      acc = in_valid && in_ready;
      hold_chk = iss_valid && !iss_ready;
      held = {iss_slow, iss_tag, iss_pfx, iss_rem};
      if (acc) begin
        if (!m_waited && m_older_same(kp)) cov_old++;
        if (m_waited) cov_slow++;
        pend_acc = 1; pend_key = in_key; pend_slow = m_waited; m_waited = 0;
        for (int i = 0; i < SLOTS; i++) busy_snap[i] = m_busy[i];
      end else if (!in_valid) m_waited = 0;
      else if (cf) m_waited = 1;
      holding = in_valid && !acc;
      if (iss_valid && iss_ready) m_hand[iss_tag] = 1;
      exp_iss_v = acc ? 1 : ((exp_iss_v && iss_ready) ? 0 : exp_iss_v);
      if (cmp_valid && m_busy[cmp_tag] && m_hand[cmp_tag]) begin
        m_busy[cmp_tag] = 0; m_hand[cmp_tag] = 0;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_busy[i] = 0; m_hand[i] = 0; m_pfx[i] = '0; end
    for (int h = 0; h < HIST; h++) m_hist[h] = -1;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(iss_valid == 0, "R1 iss_valid", iss_valid, 0);
    chk(fast_cnt == 0 && slow_cnt == 0, "R1 counters", fast_cnt + slow_cnt, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    run_phase(2000, 90, 90, 15, 3);   // cap pressure, frequent prefix reuse
    run_phase(2000, 70, 60, 50, 3);   // back-pressure and many completions
    run_phase(1500, 80, 100, 70, 16); // wide prefix spread
    chk(cov_slow > 0, "R4 slow issues seen", cov_slow, 1);
    chk(cov_full > 0, "R6 cap reached", cov_full, 1);
    chk(cov_old > 0, "R10 older same prefix not blocking", cov_old, 1);
    chk(cov_stray > 0, "R8 stray completions sent", cov_stray, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule